// File: doc/BRIEF.md
# Colour Palette Index and Data Port

This block holds two colour tables, one for background tiles and one for objects, and gives the CPU byte-wide access to both through a pair of registers per table. One register is a byte pointer into the table; the other is a data window onto the byte that the pointer selects. Each table holds 32 colour words of 15 bits. The pointer is 6 bits wide. Its lowest bit picks the low byte or the high byte of a word, and its upper five bits pick the word.

Each table has its own step flag. When the flag is set, every data write advances that table's pointer by one and wraps from 63 to 0. Software can therefore fill a whole table with one pointer write followed by a stream of data writes. The display side has a separate read port. It addresses a single 64-word space in which the background words sit at 0 to 31 and the object words sit at 32 to 63. It returns a whole colour word one clock after the address is applied.

Top module: `pal_port_top`

## Requirements
- R1: After reset, the background pointer register reads 0xC0 (step on, pointer 0) and the object pointer register reads 0x40. Both data windows read 0x00, and every colour word is 0.
- R2: A write to a pointer register loads bits 5:0 into the pointer and bit 7 into the step flag. On read, bit 6 of a pointer register is always 1, whatever value was written.
- R3: A data-window read returns the low byte (bits 7:0) of word pointer>>1 when the pointer is even. When the pointer is odd, it returns the high byte, bits 14:8 in bits 6:0, and bit 7 reads 0.
- R4: A data write changes only the byte that the pointer selects. On a high-byte write, bit 7 of the written value is dropped.
- R5: A data write with the step flag set leaves the pointer at (pointer+1) mod 64.
- R6: A data write with the step flag clear leaves the pointer unchanged.
- R7: Display address n with n<32 returns background word n, and address 32+n returns object word n. The word appears on the display output one clock after the address.
- R8: Bit 15 of the display output is always 0.
- R9: The data window shows the byte at a new pointer in the cycle right after the pointer write.
- R10: An access to one table leaves the other table's pointer, flag and contents unchanged.

CPU register select, cpu_addr_i: 0 is the background pointer, 1 the background data window, 2 the object pointer, 3 the object data window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_we_i | input | 1 | Write strobe for the selected register |
| cpu_addr_i | input | 2 | Register select (bit 1 picks the table, bit 0 picks the data window) |
| cpu_wdata_i | input | 8 | Write data |
| cpu_rdata_o | output | 8 | Read data of the selected register, combinational |
| disp_addr_i | input | 6 | Display word address |
| disp_color_o | output | 16 | Display colour word, registered |

## Verification
If the pointer goes wrong, it shows on the very next read of a pointer register. It also shows on the next data-window read, because that read returns the wrong byte. If a colour word goes wrong, the display port shows it one clock after that word is addressed, and the data window shows it as soon as the pointer reaches the word. A write that lands in the wrong table, the wrong word or the wrong byte only shows when the disturbed location is read back. For that reason the bench reads neighbouring bytes, the other table's pointer, and both ends of the display address space.

// File: rtl/pal_pkg.sv
package pal_pkg;
  typedef enum logic [1:0] {
    SEL_BG_PTR = 2'd0,
    SEL_BG_DAT = 2'd1,
    SEL_OB_PTR = 2'd2,
    SEL_OB_DAT = 2'd3
  } cpu_sel_e;

  typedef struct packed {
    logic       step;
    logic [5:0] ptr;
  } ptr_reg_t;
endpackage

// File: rtl/pal_ptr_ctl.sv
module pal_ptr_ctl
  import pal_pkg::*;
#(
  parameter logic RST_STEP = 1'b0
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     ptr_we_i,
  input  logic     dat_we_i,
  input  logic [7:0] wdata_i,
  output ptr_reg_t state_o
);
  ptr_reg_t st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q.step <= RST_STEP;
      st_q.ptr  <= '0;
    end else if (ptr_we_i) begin
      st_q.step <= wdata_i[7];
      st_q.ptr  <= wdata_i[5:0];
    end else if (dat_we_i && st_q.step) begin
      st_q.ptr  <= st_q.ptr + 6'd1;
    end
  end

  assign state_o = st_q;

  a_r2_ptr_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_we_i |=> (state_o.ptr == $past(wdata_i[5:0])) && (state_o.step == $past(wdata_i[7])));
  a_r5_step_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_we_i && !ptr_we_i && state_o.step) |=> state_o.ptr == 6'($past(state_o.ptr) + 6'd1));
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_we_i && !ptr_we_i && !state_o.step) |=> $stable(state_o));
endmodule

// File: rtl/pal_color_ram.sv
module pal_color_ram #(
  parameter int WORDS   = 64,
  parameter int COLOR_W = 15,
  localparam int AW     = $clog2(WORDS),
  localparam int HI_W   = COLOR_W - 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [AW-1:0]      waddr_i,
  input  logic               whi_i,
  input  logic [7:0]         wdata_i,
  input  logic [AW-1:0]      craddr_i,
  output logic [COLOR_W-1:0] crdata_o,
  input  logic [AW-1:0]      draddr_i,
  output logic [COLOR_W-1:0] drdata_o
);
  logic [COLOR_W-1:0] mem_q [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[w] <= '0;
      end else if (we_i && waddr_i == AW'(w)) begin
        if (whi_i) mem_q[w][COLOR_W-1:8] <= wdata_i[HI_W-1:0];
        else       mem_q[w][7:0]         <= wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drdata_o <= '0;
    else         drdata_o <= mem_q[draddr_i];
  end

  assign crdata_o = mem_q[craddr_i];

  // untouched byte of the written word keeps its value
  a_r4_hi_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !whi_i) |=> mem_q[$past(waddr_i)][COLOR_W-1:8] == $past(mem_q[waddr_i][COLOR_W-1:8]));
  a_r4_lo_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && whi_i) |=> mem_q[$past(waddr_i)][7:0] == $past(mem_q[waddr_i][7:0]));
endmodule

// File: rtl/pal_port_top.sv
module pal_port_top
  import pal_pkg::*;
#(
  parameter int SET_WORDS = 32,
  parameter int COLOR_W   = 15
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cpu_we_i,
  input  logic [1:0]  cpu_addr_i,
  input  logic [7:0]  cpu_wdata_i,
  output logic [7:0]  cpu_rdata_o,
  input  logic [5:0]  disp_addr_i,
  output logic [15:0] disp_color_o
);
  localparam int WORDS = 2 * SET_WORDS;
  localparam int AW    = $clog2(WORDS);
  localparam int WW    = $clog2(SET_WORDS);
  localparam int HI_W  = COLOR_W - 8;

  ptr_reg_t       st [2];
  logic [1:0]     ptr_we, dat_we;

  for (genvar s = 0; s < 2; s++) begin : g_set
    assign ptr_we[s] = cpu_we_i && cpu_addr_i[1] == s[0] && !cpu_addr_i[0];
    assign dat_we[s] = cpu_we_i && cpu_addr_i[1] == s[0] &&  cpu_addr_i[0];
    pal_ptr_ctl #(.RST_STEP(s == 0)) u_ptr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ptr_we_i (ptr_we[s]),
      .dat_we_i (dat_we[s]),
      .wdata_i  (cpu_wdata_i),
      .state_o  (st[s])
    );
  end

  logic               set_sel;
  ptr_reg_t           cur;
  logic [AW-1:0]      word_addr;
  logic [COLOR_W-1:0] cpu_word, disp_word;

  assign set_sel   = cpu_addr_i[1];
  assign cur       = st[set_sel];
  assign word_addr = {set_sel, cur.ptr[WW:1]};

  pal_color_ram #(.WORDS(WORDS), .COLOR_W(COLOR_W)) u_ram (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (|dat_we),
    .waddr_i  (word_addr),
    .whi_i    (cur.ptr[0]),
    .wdata_i  (cpu_wdata_i),
    .craddr_i (word_addr),
    .crdata_o (cpu_word),
    .draddr_i (disp_addr_i),
    .drdata_o (disp_word)
  );

  always_comb begin
    if (!cpu_addr_i[0])  cpu_rdata_o = {cur.step, 1'b1, cur.ptr};
    else if (cur.ptr[0]) cpu_rdata_o = {{(8-HI_W){1'b0}}, cpu_word[COLOR_W-1:8]};
    else                 cpu_rdata_o = cpu_word[7:0];
  end

  assign disp_color_o = {{(16-COLOR_W){1'b0}}, disp_word};

  a_r10_bg_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_we_i && cpu_addr_i[1]) |=> $stable(st[0]));
  a_r10_ob_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_we_i && !cpu_addr_i[1]) |=> $stable(st[1]));
endmodule

// File: tb/pal_port_top_tb.sv
module pal_port_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [5:0]  daddr = '0;
  logic [15:0] dcolor;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  pal_port_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cpu_we_i(we), .cpu_addr_i(addr),
    .cpu_wdata_i(wdata), .cpu_rdata_o(rdata), .disp_addr_i(daddr), .disp_color_o(dcolor)
  );

  typedef struct packed {
    logic       w;
    logic [1:0] a;
    logic [7:0] d;
    logic [1:0] ca;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd0, 8'h80, 2'd0, 8'hC0, 4'd2},  // R2 step on, ptr 0
    '{1'b1, 2'd1, 8'h34, 2'd0, 8'hC1, 4'd5},  // R5 step
    '{1'b0, 2'd0, 8'h00, 2'd1, 8'h00, 4'd3},  // R3 odd ptr, high byte
    '{1'b1, 2'd1, 8'hFF, 2'd0, 8'hC2, 4'd5},  // R5 step again
    '{1'b1, 2'd0, 8'h01, 2'd1, 8'h7F, 4'd4},  // R4 bit 7 dropped, R9 refresh
    '{1'b1, 2'd0, 8'h00, 2'd1, 8'h34, 4'd9},  // R9 refresh to low byte
    '{1'b1, 2'd1, 8'h56, 2'd0, 8'h40, 4'd6},  // R6 no step
    '{1'b0, 2'd0, 8'h00, 2'd1, 8'h56, 4'd4},  // R4 low byte rewritten
    '{1'b1, 2'd0, 8'h01, 2'd1, 8'h7F, 4'd4},  // R4 high byte kept
    '{1'b1, 2'd2, 8'hBF, 2'd2, 8'hFF, 4'd2},  // R2 obj ptr 63
    '{1'b1, 2'd3, 8'h12, 2'd2, 8'hC0, 4'd5},  // R5 wrap 63 -> 0
    '{1'b1, 2'd2, 8'h3F, 2'd3, 8'h12, 4'd3},  // R3 obj word 31 high
    '{1'b0, 2'd0, 8'h00, 2'd0, 8'h41, 4'd10}, // R10 bg ptr untouched
    '{1'b1, 2'd2, 8'h3E, 2'd2, 8'h7E, 4'd2}   // R2 bit 6 forced
  };

  task automatic check(input int req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cpu_rd(input logic [1:0] a, input int req, input logic [7:0] exp);
    @(negedge clk);
    we = 1'b0; addr = a;
    #1 check(req, {8'h00, rdata}, {8'h00, exp});
  endtask

  task automatic disp_rd(input logic [5:0] a, input int req, input logic [15:0] exp);
    @(negedge clk);
    daddr = a;
    @(negedge clk);
    check(req, dcolor, exp);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    cpu_rd(2'd0, 1, 8'hC0);
    cpu_rd(2'd2, 1, 8'h40);
    cpu_rd(2'd1, 1, 8'h00);
    cpu_rd(2'd3, 1, 8'h00);
    disp_rd(6'd40, 1, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      we = VEC[i].w; addr = VEC[i].a; wdata = VEC[i].d;
      @(negedge clk);
      we = 1'b0; addr = VEC[i].ca;
      #1 check(int'(VEC[i].req), {8'h00, rdata}, {8'h00, VEC[i].exp});
    end

    // R7 R8 display mapping and unused top bit
    disp_rd(6'd0, 7, 16'h7F56);
    disp_rd(6'd63, 7, 16'h1200);
    disp_rd(6'd32, 7, 16'h0000);
    disp_rd(6'd31, 8, 16'h0000);

    // R10 object write leaves background word 0 alone
    @(negedge clk); we = 1'b1; addr = 2'd2; wdata = 8'h80;
    @(negedge clk); addr = 2'd3; wdata = 8'hAA;
    @(negedge clk); we = 1'b0;
    disp_rd(6'd0, 10, 16'h7F56);
    disp_rd(6'd32, 7, 16'h00AA);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule